// File: doc/BRIEF.md
# Load-Use Interlock and Operand Bypass Control

This block decides, for a five-stage in-order pipeline, where the execute stage takes its two ALU operands from. The stages are instruction fetch, decode with register read, execute (shift, ALU, load/store address), data memory access, and register write-back. The block also decides whether the front of the pipe must wait for one cycle. It compares the source register indices of the instruction in execute with the destination indices of the older instructions in the memory and write-back stages. It then drives one select per operand for the bypass multiplexers of the datapath. When a register is in flight, the bypass replaces the register file value with the newest copy.

A load only has its data at the end of the memory stage. If the instruction directly behind a load reads the loaded register, the unit raises a stall for one cycle. The stall holds the fetch and decode pipeline registers. At the same time the unit raises a bubble, which loads a no-op into execute. One cycle later the load sits in write-back, and its data reaches the consumer through the write-back bypass. No stall is ever needed between two ALU instructions.

Top module: `hzd_unit`

## Requirements
- R1: An execute-stage source takes select code 1 (memory-stage result) when the memory-stage instruction writes that register and is not a load.
- R2: An execute-stage source takes select code 2 (write-back value) when the write-back-stage instruction writes that register and the memory stage gives no match under R1.
- R3: When the memory-stage and write-back-stage instructions both write the source register, code 1 wins, because the youngest producer has priority.
- R4: In every other case the select is code 0 (register file). A producer with its write enable low never causes a bypass, even when its index matches.
- R5: A load in the memory stage is never a bypass source. The select falls through to code 2 on a write-back match, or to code 0 otherwise.
- R6: Stall is high exactly when the execute-stage instruction is a load, its write enable is high, and its destination equals either decode-stage source index. A load followed by a dependent instruction therefore costs exactly one stall cycle, and a load two instructions ahead of its consumer costs none.
- R7: Bubble is high in exactly the cycles where stall is high. A load whose write enable is low, or a non-load in execute, raises neither signal.
- R8: The two operand selects are decided independently, so the two sources may take different selects in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs_i | input | NUM_SRC*RIDX_W | Source register indices of the instruction in decode |
| ex_rs_i | input | NUM_SRC*RIDX_W | Source register indices of the instruction in execute |
| ex_rd_i | input | RIDX_W | Destination index in execute |
| ex_we_i | input | 1 | Register write enable in execute |
| ex_load_i | input | 1 | Execute-stage instruction is a load |
| mem_rd_i | input | RIDX_W | Destination index in memory stage |
| mem_we_i | input | 1 | Register write enable in memory stage |
| mem_load_i | input | 1 | Memory-stage instruction is a load |
| wb_rd_i | input | RIDX_W | Destination index in write-back |
| wb_we_i | input | 1 | Register write enable in write-back |
| fwd_sel_o | output | NUM_SRC*2 | Per-operand select: 0 register file, 1 memory stage, 2 write-back |
| stall_o | output | 1 | Hold fetch and decode pipeline registers |
| bubble_o | output | 1 | Insert a no-op into execute |

## Verification
The hardest case to reach is a load in the memory stage whose destination matches a source in execute. A correct pipeline never lets this happen, because the interlock always puts a bubble between the two. A bench that only runs instruction streams therefore never exercises R5. For this reason the bench runs in two ways. First, it moves directed and pseudo-random instruction streams through a model pipeline that obeys the expected stalls. Second, it drives the stage inputs directly, to build the states a stalling pipe cannot reach: a load in memory with a matching consumer, and matching producers whose write enable is low.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'd0,
    FWD_MEM = 2'd1,
    FWD_WB  = 2'd2
  } fwd_sel_e;
endpackage

// File: rtl/hzd_fwd_pick.sv
module hzd_fwd_pick
  import hzd_pkg::*;
#(
  parameter int RIDX_W = 5
) (
  input  logic [RIDX_W-1:0] src_i,
  input  logic [RIDX_W-1:0] mem_rd_i,
  input  logic              mem_we_i,
  input  logic              mem_load_i,
  input  logic [RIDX_W-1:0] wb_rd_i,
  input  logic              wb_we_i,
  output fwd_sel_e          sel_o
);
  logic mem_hit, wb_hit;

  // loaded data is not on the memory-stage result path
  assign mem_hit = mem_we_i && !mem_load_i && (mem_rd_i == src_i);
  assign wb_hit  = wb_we_i && (wb_rd_i == src_i);

  always_comb begin
    if (mem_hit)     sel_o = FWD_MEM;
    else if (wb_hit) sel_o = FWD_WB;
    else             sel_o = FWD_RF;
  end

  always_comb begin
    // R5
    no_mem_load_fwd_chk: assert (!(sel_o == FWD_MEM && mem_load_i))
      else $error("memory-stage load used as bypass source");
    // R4
    fwd_needs_we_chk: assert (!(sel_o == FWD_MEM && !mem_we_i) && !(sel_o == FWD_WB && !wb_we_i))
      else $error("bypass from producer with write enable low");
    // R2
    wb_index_chk: assert (!(sel_o == FWD_WB && wb_rd_i != src_i))
      else $error("write-back bypass on index mismatch");
  end
endmodule

// File: rtl/hzd_load_interlock.sv
module hzd_load_interlock #(
  parameter int RIDX_W  = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0][RIDX_W-1:0] id_rs_i,
  input  logic [RIDX_W-1:0]              ex_rd_i,
  input  logic                           ex_we_i,
  input  logic                           ex_load_i,
  output logic                           stall_o
);
  logic [NUM_SRC-1:0] hit;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign hit[s] = (id_rs_i[s] == ex_rd_i);
  end

  assign stall_o = ex_load_i && ex_we_i && (|hit);

  always_comb begin
    // R7
    no_stall_without_load_chk: assert (!(stall_o && !(ex_load_i && ex_we_i)))
      else $error("stall raised without writing load in execute");
  end
endmodule

// File: rtl/hzd_unit.sv
module hzd_unit
  import hzd_pkg::*;
#(
  parameter int RIDX_W  = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0][RIDX_W-1:0] id_rs_i,
  input  logic [NUM_SRC-1:0][RIDX_W-1:0] ex_rs_i,
  input  logic [RIDX_W-1:0]              ex_rd_i,
  input  logic                           ex_we_i,
  input  logic                           ex_load_i,
  input  logic [RIDX_W-1:0]              mem_rd_i,
  input  logic                           mem_we_i,
  input  logic                           mem_load_i,
  input  logic [RIDX_W-1:0]              wb_rd_i,
  input  logic                           wb_we_i,
  output logic [NUM_SRC-1:0][1:0]        fwd_sel_o,
  output logic                           stall_o,
  output logic                           bubble_o
);
  fwd_sel_e sel [NUM_SRC];
  logic     interlock;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_op
    hzd_fwd_pick #(.RIDX_W(RIDX_W)) i_pick (
      .src_i      (ex_rs_i[s]),
      .mem_rd_i   (mem_rd_i),
      .mem_we_i   (mem_we_i),
      .mem_load_i (mem_load_i),
      .wb_rd_i    (wb_rd_i),
      .wb_we_i    (wb_we_i),
      .sel_o      (sel[s])
    );
    assign fwd_sel_o[s] = sel[s];
  end

  hzd_load_interlock #(.RIDX_W(RIDX_W), .NUM_SRC(NUM_SRC)) i_ilk (
    .id_rs_i   (id_rs_i),
    .ex_rd_i   (ex_rd_i),
    .ex_we_i   (ex_we_i),
    .ex_load_i (ex_load_i),
    .stall_o   (interlock)
  );

  assign stall_o  = interlock;
  assign bubble_o = interlock;

  always_comb begin
    // R7
    bubble_tracks_stall_chk: assert (bubble_o == stall_o)
      else $error("bubble and stall disagree");
    // R6
    stall_index_chk: assert (!(stall_o && !(ex_rd_i == id_rs_i[0] || ex_rd_i == id_rs_i[NUM_SRC-1]) && NUM_SRC <= 2))
      else $error("stall without index match");
  end
endmodule

// File: tb/test_hzd_unit.sv
`timescale 1ns/1ps
module test_hzd_unit;
  typedef struct packed {
    logic [4:0] rd;
    logic [4:0] rs0;
    logic [4:0] rs1;
    logic       we;
    logic       ld;
  } ins_t;

  localparam ins_t NOP = '0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  ins_t id_s, ex_s, mem_s, wb_s;
  ins_t prog [0:511];
  int   checks = 0, failures = 0, dut_stalls = 0;
  bit   done = 0;

  logic [1:0][4:0] id_rs, ex_rs;
  logic [1:0][1:0] fwd_sel;
  logic stall, bubble;

  assign id_rs = {id_s.rs1, id_s.rs0};
  assign ex_rs = {ex_s.rs1, ex_s.rs0};

  hzd_unit i_hzd_unit (
    .id_rs_i(id_rs), .ex_rs_i(ex_rs),
    .ex_rd_i(ex_s.rd), .ex_we_i(ex_s.we), .ex_load_i(ex_s.ld),
    .mem_rd_i(mem_s.rd), .mem_we_i(mem_s.we), .mem_load_i(mem_s.ld),
    .wb_rd_i(wb_s.rd), .wb_we_i(wb_s.we),
    .fwd_sel_o(fwd_sel), .stall_o(stall), .bubble_o(bubble)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_sel(input logic [4:0] src, output string tag);
    bit wb_match = wb_s.we && wb_s.rd == src;
    bit mem_match = mem_s.we && mem_s.rd == src;
    if (mem_match && !mem_s.ld) begin
      tag = wb_match ? "R3" : "R1";
      return 1;
    end
    if (wb_match) begin
      tag = mem_match ? "R5" : "R2";
      return 2;
    end
    tag = "R4";
    return 0;
  endfunction

  function automatic bit exp_stall();
    return ex_s.ld && ex_s.we && (ex_s.rd == id_s.rs0 || ex_s.rd == id_s.rs1);
  endfunction

  task automatic check_now();
    string t0, t1;
    int e0, e1;
    e0 = exp_sel(ex_s.rs0, t0);
    e1 = exp_sel(ex_s.rs1, t1);
    chk({t0, " op0"}, fwd_sel[0], e0);
    chk({t1, " op1"}, fwd_sel[1], e1);
    chk("R6 stall", stall, exp_stall());
    chk("R7 bubble", bubble, exp_stall());
    if (stall) dut_stalls++;
  endtask

  task automatic run_prog(input int n);
    int idx = 0;
    id_s = NOP; ex_s = NOP; mem_s = NOP; wb_s = NOP;
    for (int cyc = 0; cyc < 4 * n + 8; cyc++) begin
      bit st;
      @(negedge clk); #1;
      check_now();
      st = exp_stall();
      wb_s = mem_s;
      mem_s = ex_s;
      if (st) ex_s = NOP;
      else begin
        ex_s = id_s;
        id_s = (idx < n) ? prog[idx] : NOP;
        if (idx < n) idx++;
      end
      if (idx >= n && id_s == NOP && ex_s == NOP && mem_s == NOP && wb_s == NOP) break;
    end
  endtask

  function automatic ins_t mk(input int rd, rs0, rs1, input bit we, ld);
    ins_t i;
    i.rd = rd[4:0]; i.rs0 = rs0[4:0]; i.rs1 = rs1[4:0]; i.we = we; i.ld = ld;
    return i;
  endfunction

  initial begin
    #50000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    id_s = NOP; ex_s = NOP; mem_s = NOP; wb_s = NOP;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R4 reset sel", fwd_sel, 0);
    chk("R7 reset stall", stall, 0);

    // directed stream
    prog[0] = mk(1, 2, 3, 1, 0);
    prog[1] = mk(4, 1, 1, 1, 0);   // both from memory stage
    prog[2] = mk(5, 1, 4, 1, 0);   // op0 write-back, op1 memory
    prog[3] = mk(6, 5, 9, 1, 1);   // load, base from memory stage
    prog[4] = mk(7, 6, 2, 1, 0);   // load-use: one stall
    prog[5] = mk(8, 0, 0, 1, 1);
    prog[6] = mk(10, 2, 3, 1, 0);
    prog[7] = mk(11, 8, 8, 1, 0);  // load two ahead: no stall
    prog[8] = mk(9, 1, 1, 0, 0);   // write enable low
    prog[9] = mk(12, 9, 9, 1, 0);
    prog[10] = mk(2, 1, 1, 1, 0);
    prog[11] = mk(2, 4, 4, 1, 0);
    prog[12] = mk(3, 2, 2, 1, 0);  // both producers match: memory wins
    dut_stalls = 0;
    run_prog(13);
    chk("R6 single stall cycle", dut_stalls, 1);

    // pseudo-random stream over four registers
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      for (int k = 0; k < 11; k++) lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      prog[i % 512] = mk(lfsr[1:0], lfsr[3:2], lfsr[5:4], lfsr[6] | lfsr[7], lfsr[8] & lfsr[9]);
      if (i % 100 == 99) run_prog(100);
    end

    // raw states a stalling pipe never reaches
    @(negedge clk);
    id_s = NOP; ex_s = NOP;
    mem_s = mk(3, 0, 0, 1, 1); wb_s = mk(3, 0, 0, 1, 0);
    ex_s = mk(0, 3, 3, 1, 0);
    #1; chk("R5 load in memory falls to write-back", fwd_sel[0], 2);
    @(negedge clk);
    wb_s = NOP; #1;
    chk("R5 load in memory falls to register file", fwd_sel[1], 0);
    @(negedge clk);
    mem_s = mk(3, 0, 0, 0, 0); wb_s = mk(3, 0, 0, 0, 0); #1;
    chk("R4 write enable low no bypass", fwd_sel, 0);
    @(negedge clk);
    mem_s = mk(1, 0, 0, 1, 0); wb_s = mk(2, 0, 0, 1, 0);
    ex_s = mk(0, 2, 1, 1, 0); #1;
    chk("R8 op0 write-back", fwd_sel[0], 2);
    chk("R8 op1 memory", fwd_sel[1], 1);
    @(negedge clk);
    ex_s = mk(1, 0, 0, 0, 1); id_s = mk(0, 1, 1, 1, 0); #1;
    chk("R7 load with write enable low stall", stall, 0);
    chk("R7 load with write enable low bubble", bubble, 0);
    @(negedge clk);
    ex_s = mk(1, 0, 0, 1, 0); #1;
    chk("R7 non-load no stall", stall, 0);
    @(negedge clk);
    ex_s = mk(1, 0, 0, 1, 1); id_s = mk(0, 4, 1, 1, 0); #1;
    chk("R6 stall on second source", stall, 1);
    chk("R7 bubble with stall", bubble, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule